// File: doc/BRIEF.md
# SPI Slave Byte-Stream Port with Idle-Fill Gating

This block is a full-duplex SPI slave for a byte-oriented message stream. Each byte the master clocks in on MOSI is matched by a byte shifted out on MISO in the same eight clock periods. Outgoing bytes are taken, in push order, from a small internal transmit FIFO that local logic fills through a valid/ready push port. When that FIFO has nothing to give, the port sends 0xFF. The master can therefore poll the port without limit and ignore the 0xFF filler.

Received bytes pass through an idle detector before they reach the local receive stream. A master with nothing to say holds MOSI high, so it sends 0xFF. The detector counts consecutive 0xFF bytes. Once the count reaches a programmable limit, further 0xFF bytes are discarded. The first byte of any other value is forwarded and restarts the count. Hosts normally program a limit of 50 and raise it only when messages carry long runs of 0xFF.

SCK, MOSI and chip select are synchronised into the system clock, and SCK edges are detected there, so SCK must be well below the system clock. A factor of eight or more suits the default two-stage synchroniser. The receive output is a one-byte holding register. Once `rx_valid` rises, the byte and the valid stay unchanged until `rx_ready` is high at a clock edge. SPI cannot be stalled, so a byte that completes while the register is still occupied and not being accepted is lost. On the transmit side a byte is taken on any clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` is low while the FIFO is full.

Top module: `spi_stream_port`

## Requirements
- R1: `cfg_mode[1]` sets the SCK idle level (CPOL) and `cfg_mode[0]` sets the data phase (CPHA). Value 0 is mode 0. Data is sampled on the leading SCK edge when CPHA=0 and on the trailing edge when CPHA=1. Both directions are MSB first, and all four modes exchange bytes correctly.
- R2: Every byte received on MOSI is matched by one byte on MISO during the same transfer. MISO bytes are the FIFO bytes in the order they were pushed.
- R3: When the transmit FIFO is empty at the start of a MISO byte, that byte is 0xFF. MISO is high while chip select is deasserted.
- R4: With a limit L, the first L bytes of a run of consecutive 0xFF bytes are forwarded. Later 0xFF bytes in the same run are dropped.
- R5: Any received byte other than 0xFF is forwarded, including while 0xFF bytes are being dropped, and it resets the run count to zero.
- R6: The limit comes from `cfg_ff_limit`. A limit of 0 drops every 0xFF byte.
- R7: Raising chip select discards a partly received byte, and the next select starts again at bit 7. The 0xFF run count is kept across chip-select deassertion.
- R8: Once `rx_valid` is high, `rx_data` holds until a clock edge with `rx_ready` high. A byte that completes while the register is full and not being accepted is dropped.
- R9: A push is taken when `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the FIFO holds DEPTH bytes, and a push offered then leaves the FIFO unchanged.
- R10: After reset, `rx_valid` is 0, `tx_ready` is 1, MISO is 1 and the run count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| cfg_mode | input | 2 | {CPOL, CPHA} |
| cfg_ff_limit | input | LIM_W | Number of consecutive 0xFF bytes forwarded before dropping |
| tx_data | input | 8 | Byte pushed into the transmit FIFO |
| tx_valid | input | 1 | Push request |
| tx_ready | output | 1 | FIFO can take a byte |
| rx_data | output | 8 | Forwarded received byte |
| rx_valid | output | 1 | `rx_data` holds a byte |
| rx_ready | input | 1 | Consumer accepts the byte |

## Verification
The hardest state to reach from the ports is a 0xFF run whose count crosses the end of a transfer. The master must send 0xFF bytes under one chip select, deassert, and select again. The bench does this with a small limit, and the drop on the second transfer can only come from a count carried over. A second hard case is a select released mid-byte: the bench clocks three bits, releases chip select, then checks that the next full byte arrives correctly aligned. A third is a full receive register: a second byte is completed while `rx_ready` is held low.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_act,
  output logic cs_start
);
  logic [STAGES-1:0] sck_q, mosi_q, cs_q;
  logic sck_d, cs_d;
  logic sck_s, cs_n_s;

  assign sck_s  = sck_q[STAGES-1];
  assign cs_n_s = cs_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '1;
      cs_q   <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      sck_d  <= sck_s;
      cs_d   <= cs_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign mosi_s   = mosi_q[STAGES-1];
  assign cs_act   = ~cs_n_s;
  assign cs_start = ~cs_n_s & cs_d;
endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_en, pop_en;

  assign push_ready = (cnt != FULL_CNT);
  assign empty      = (cnt == '0);
  assign push_en    = push_valid && push_ready;
  assign pop_en     = pop && !empty;
  assign pop_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_en) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_en) wp <= wp + AW'(1);
      if (pop_en)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(push_en) - CW'(pop_en);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import spi_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  spi_mode_t         mode,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              miso,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_done
);
  logic              samp_edge, shift_edge, load_now, load_pend;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] tx_sh, rx_sh, load_val;

  assign samp_edge  = (mode.cpol ^ mode.cpha) ? sck_fall : sck_rise;
  assign shift_edge = (mode.cpol ^ mode.cpha) ? sck_rise : sck_fall;
  assign load_now   = cs_act && ((cs_start && !mode.cpha) ||
                                 (!cs_start && shift_edge && load_pend));
  assign load_val   = tx_empty ? IDLE_BYTE : tx_byte;
  assign tx_pop     = load_now && !tx_empty;
  assign miso       = cs_act ? tx_sh[BYTE_W-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      load_pend <= 1'b0;
      tx_sh     <= IDLE_BYTE;
      rx_sh     <= '0;
      rx_byte   <= '0;
      rx_done   <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt   <= '0;
      load_pend <= 1'b0;
      tx_sh     <= IDLE_BYTE;
      rx_done   <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (cs_start && mode.cpha) load_pend <= 1'b1;
      if (load_now) begin
        tx_sh     <= load_val;
        load_pend <= 1'b0;
      end else if (shift_edge && !cs_start) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
      end
      if (samp_edge && !cs_start) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_done   <= 1'b1;
          rx_byte   <= {rx_sh[BYTE_W-2:0], mosi_s};
          load_pend <= 1'b1;
        end
      end
    end
  end

  assert_bitcnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == 3'd0));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: rtl/ssp_idle_gate.sv
module ssp_idle_gate
  import spi_stream_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [LIM_W-1:0]  limit,
  output logic              fwd
);
  logic [LIM_W-1:0] run_q;
  logic             is_idle;

  assign is_idle = (in_byte == IDLE_BYTE);
  assign fwd     = in_valid && (!is_idle || (run_q < limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (in_valid) begin
      if (!is_idle)            run_q <= '0;
      else if (run_q < limit)  run_q <= run_q + LIM_W'(1);
    end
  end

  assert_drop_holds_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_idle && !fwd) |=> $stable(run_q));

  assert_resume_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_idle) |=> (run_q == '0));
endmodule

// File: rtl/spi_stream_port.sv
module spi_stream_port
  import spi_stream_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TX_DEPTH    = 8,
  parameter int unsigned LIM_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [1:0]       cfg_mode,
  input  logic [LIM_W-1:0] cfg_ff_limit,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready
);
  spi_mode_t         mode;
  logic              sck_rise, sck_fall, mosi_s, cs_act, cs_start;
  logic              tx_pop, tx_empty, byte_done, fwd;
  logic [BYTE_W-1:0] fifo_out, rx_byte;

  assign mode = spi_mode_t'(cfg_mode);

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_n_i(spi_cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .cs_act(cs_act), .cs_start(cs_start)
  );

  ssp_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_valid(tx_valid), .push_ready(tx_ready),
    .push_data(tx_data), .pop(tx_pop), .pop_data(fifo_out), .empty(tx_empty)
  );

  ssp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .cs_act(cs_act),
    .cs_start(cs_start), .tx_byte(fifo_out), .tx_empty(tx_empty),
    .tx_pop(tx_pop), .miso(spi_miso), .rx_byte(rx_byte), .rx_done(byte_done)
  );

  ssp_idle_gate #(.LIM_W(LIM_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(byte_done), .in_byte(rx_byte),
    .limit(cfg_ff_limit), .fwd(fwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (fwd && (!rx_valid || rx_ready)) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_miso_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> spi_miso);
endmodule

// File: tb/spi_stream_port_tb.sv
module spi_stream_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b1;
  logic       spi_miso;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_ff_limit = 8'd50;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready = 1'b0;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  spi_stream_port u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_mode(cfg_mode),
    .cfg_ff_limit(cfg_ff_limit), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  // {mosi byte, expected miso byte, expected forward}
  localparam logic [16:0] VEC [8] = '{
    {8'h12, 8'hA5, 1'b1}, {8'hFF, 8'h3C, 1'b1}, {8'hFF, 8'hFF, 1'b1},
    {8'hFF, 8'hFF, 1'b1}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0},
    {8'h00, 8'hFF, 1'b1}, {8'hFF, 8'hFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_begin();
    spi_sck = cfg_mode[1];
    half();
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic cs_end();
    half();
    spi_cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'hFF;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cfg_mode[0]) begin
        spi_mosi = mo[i]; half(); mi[i] = spi_miso;
        spi_sck = ~spi_sck; half(); spi_sck = ~spi_sck;
      end else begin
        spi_sck = ~spi_sck; spi_mosi = mo[i]; half(); mi[i] = spi_miso;
        spi_sck = ~spi_sck; half();
      end
    end
    spi_mosi = 1'b1;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic check_rx(input string tag, input logic exp_fwd, input logic [7:0] exp_b);
    repeat (4) @(negedge clk);
    chk(tag, {7'd0, rx_valid}, {7'd0, exp_fwd});
    if (exp_fwd) chk(tag, rx_data, exp_b);
    if (rx_valid) begin
      rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    end
  endtask

  task automatic xfer(input string tag, input logic [7:0] mo, input logic [7:0] exp_mi,
                      input logic exp_fwd);
    logic [7:0] mi;
    spi_bits(mo, 8, mi);
    chk(tag, mi, exp_mi);
    check_rx(tag, exp_fwd, mo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 miso", {7'd0, spi_miso}, 8'd1);
    chk("R10 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R10 tx_ready", {7'd0, tx_ready}, 8'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table: R2 order, R3 fill, R4 run limit, R5 resume (mode 0, limit 3)
    cfg_ff_limit = 8'd3;
    push(8'hA5); push(8'h3C);
    cs_begin();
    for (int v = 0; v < 8; v++)
      xfer("R2/R3/R4/R5 table", VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
    cs_end();
    chk("R3 miso idle", {7'd0, spi_miso}, 8'd1);

    // R7: run count kept across chip select (count is 1 now)
    cfg_ff_limit = 8'd2;
    cs_begin(); xfer("R7 ff before deselect", 8'hFF, 8'hFF, 1'b1); cs_end();
    cs_begin(); xfer("R7 ff after deselect dropped", 8'hFF, 8'hFF, 1'b0);
    xfer("R5 clear", 8'h5A, 8'hFF, 1'b1); cs_end();

    // R6: limit 0 drops every 0xFF
    cfg_ff_limit = 8'd0;
    cs_begin();
    xfer("R6 limit0 drop", 8'hFF, 8'hFF, 1'b0);
    xfer("R6 non-ff passes", 8'h81, 8'hFF, 1'b1);
    cs_end();

    // R1: modes 1..3
    cfg_ff_limit = 8'd50;
    for (int m = 1; m < 4; m++) begin
      cfg_mode = 2'(m);
      push(8'h40 + 8'(m)); push(8'hC0 + 8'(m));
      cs_begin();
      xfer("R1 mode byte0", 8'h20 + 8'(m), 8'h40 + 8'(m), 1'b1);
      xfer("R1 mode byte1", 8'h9A + 8'(m), 8'hC0 + 8'(m), 1'b1);
      cs_end();
    end
    cfg_mode = 2'b00;

    // R7: partial byte discarded on deselect
    cs_begin(); spi_bits(8'h00, 3, mi); cs_end();
    check_rx("R7 partial not forwarded", 1'b0, 8'h00);
    cs_begin(); xfer("R7 realigned", 8'h6B, 8'hFF, 1'b1); cs_end();

    // R8: back-pressure
    cs_begin();
    spi_bits(8'h11, 8, mi);
    spi_bits(8'h22, 8, mi);
    repeat (4) @(negedge clk);
    chk("R8 held valid", {7'd0, rx_valid}, 8'd1);
    chk("R8 held data", rx_data, 8'h11);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    chk("R8 second dropped", {7'd0, rx_valid}, 8'd0);
    cs_end();

    // R9: FIFO full
    for (int k = 0; k < 8; k++) push(8'h80 + 8'(k));
    chk("R9 full", {7'd0, tx_ready}, 8'd0);
    push(8'h99);
    cs_begin();
    for (int k = 0; k < 8; k++) xfer("R9 R2 drain", 8'h01, 8'h80 + 8'(k), 1'b1);
    xfer("R9 rejected push absent", 8'h02, 8'hFF, 1'b1);
    cs_end();
    chk("R9 ready again", {7'd0, tx_ready}, 8'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule